// File: doc/BRIEF.md
# Split Address Button Encoder with Validity Strobe

This block serves a bank of fifteen push buttons. Each button picks one of fifteen split-time slots. The block filters contact bounce on every button and turns the pressed button into a nonzero 4-bit slot number.

When a press is accepted, the block raises a positive strobe for a fixed number of clock cycles. The slot number counts as meaningful only while that strobe is high. The block then arms again only after every button has been released cleanly.

A separate holding register keeps the slot number for the controller. The controller fills it by raising a latch command. A rising edge of that command while the strobe is high stores the slot number and marks it valid. A rising edge at any other time empties the register. The controller reads the slot number and the valid flag from the register and uses them to address its split memory.

Top module: `split_addr_encoder`

## Requirements
- R1: During and right after reset, `strobe` is 0, `slot_addr` is 0 and `slot_valid` is 0.
- R2: A change on a button that lasts fewer than DEBOUNCE_CYCLES clock cycles is ignored and produces no strobe.
- R3: An accepted press drives `strobe` high for exactly STROBE_CYCLES consecutive clock cycles.
- R4: Bit i of `btn_raw` (i = 0..14) encodes to slot number i+1. When several buttons are down, the highest-numbered one wins.
- R5: After a strobe, no new strobe starts while any filtered button is still down. This holds even if further buttons are pressed. A fresh strobe needs all buttons released first.
- R6: A rising edge of `latch_cmd` sampled while `strobe` is high stores the encoded slot number in `slot_addr` and sets `slot_valid` to 1. Both are visible one clock later.
- R7: A rising edge of `latch_cmd` sampled while `strobe` is low sets `slot_addr` to 0 and `slot_valid` to 0.
- R8: `slot_addr` and `slot_valid` change only on a rising edge of `latch_cmd`. Holding the command high across a strobe captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_raw | input | 15 | Raw button levels, bit i is button i+1, high = pressed |
| latch_cmd | input | 1 | Latch command from the controller, acts on its rising edge |
| strobe | output | 1 | High while the encoded slot number is valid |
| slot_addr | output | 4 | Latched slot number, 0 when empty |
| slot_valid | output | 1 | Latched slot number came from inside a strobe |

## Verification
The hardest cases to reach are the re-arm rule and the level-held latch command. The re-arm rule means a strobe must not repeat while buttons stay down, even when more buttons join after the first strobe ends. To reach it, the stimulus holds one button through and past its strobe, adds a second button, and waits long enough that any wrongly re-armed strobe would show up. It then releases everything and shows that a new press is accepted again. For the latch, the command is raised outside a strobe, which empties the register. It is then held high through a later strobe, so a design that captures on the level instead of the edge would show a changed address.

// File: rtl/split_addr_pkg.sv
package split_addr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } strobe_state_e;

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int NUM_BTN         = 15,
    parameter int DEBOUNCE_CYCLES = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] raw,
    output logic [NUM_BTN-1:0] clean
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
        typedef struct packed {
            logic [1:0]    sync;
            logic          level;
            logic [CW-1:0] cnt;
        } db_t;

        db_t d, q;

        always_comb begin
            d      = q;
            d.sync = {q.sync[0], raw[g]};
            if (q.sync[1] != q.level) begin
                if (q.cnt == CW'(DEBOUNCE_CYCLES - 1)) begin
                    d.level = q.sync[1];
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                d.cnt = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        assign clean[g] = q.level;
    end
endmodule

// File: rtl/btn_prio_enc.sv
module btn_prio_enc #(
    parameter int NUM_BTN = 15,
    parameter int ADDR_W  = 4
) (
    input  logic [NUM_BTN-1:0] btn,
    output logic [ADDR_W-1:0]  code
);
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_BTN; i++) begin
            if (btn[i]) code = ADDR_W'(i + 1);
        end
    end
endmodule

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
    import split_addr_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int STROBE_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_btn,
    input  logic [ADDR_W-1:0] code_in,
    output logic              strobe,
    output logic [ADDR_W-1:0] code_held
);
    localparam int CW = $clog2(STROBE_CYCLES + 1);

    typedef struct packed {
        strobe_state_e     st;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] code;
    } sc_t;

    sc_t d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (any_btn) begin
                    d.st   = ST_PULSE;
                    d.cnt  = '0;
                    d.code = code_in;
                end
            end
            ST_PULSE: begin
                if (q.cnt == CW'(STROBE_CYCLES - 1)) d.st = ST_HOLD;
                else                                 d.cnt = q.cnt + 1'b1;
            end
            ST_HOLD: begin
                if (!any_btn) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, code: '0};
        else        q <= d;
    end

    assign strobe    = (q.st == ST_PULSE);
    assign code_held = q.code;
endmodule

// File: rtl/split_addr_encoder.sv
module split_addr_encoder #(
    parameter int NUM_BTN         = 15,
    parameter int DEBOUNCE_CYCLES = 10,
    parameter int STROBE_CYCLES   = 10,
    parameter int ADDR_W          = $clog2(NUM_BTN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] btn_raw,
    input  logic               latch_cmd,
    output logic               strobe,
    output logic [ADDR_W-1:0]  slot_addr,
    output logic               slot_valid
);
    logic [NUM_BTN-1:0] btn_clean;
    logic [ADDR_W-1:0]  enc_code;
    logic [ADDR_W-1:0]  held_code;

    btn_debounce #(.NUM_BTN(NUM_BTN), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_db (
        .clk(clk), .rst_n(rst_n), .raw(btn_raw), .clean(btn_clean)
    );

    btn_prio_enc #(.NUM_BTN(NUM_BTN), .ADDR_W(ADDR_W)) u_enc (
        .btn(btn_clean), .code(enc_code)
    );

    strobe_ctrl #(.ADDR_W(ADDR_W), .STROBE_CYCLES(STROBE_CYCLES)) u_stb (
        .clk(clk), .rst_n(rst_n), .any_btn(|btn_clean), .code_in(enc_code),
        .strobe(strobe), .code_held(held_code)
    );

    typedef struct packed {
        logic              cmd_prev;
        logic [ADDR_W-1:0] addr;
        logic              valid;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d          = lat_q;
        lat_d.cmd_prev = latch_cmd;
        if (latch_cmd && !lat_q.cmd_prev) begin
            lat_d.addr  = strobe ? held_code : '0;
            lat_d.valid = strobe;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign slot_addr  = lat_q.addr;
    assign slot_valid = lat_q.valid;
endmodule

// File: rtl/split_addr_encoder_chk.sv
module split_addr_encoder_chk #(
    parameter int ADDR_W        = 4,
    parameter int STROBE_CYCLES = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              latch_cmd,
    input logic              strobe,
    input logic [ADDR_W-1:0] slot_addr,
    input logic              slot_valid
);
    localparam int CW = $clog2(STROBE_CYCLES + 2);
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (strobe) run_q <= (run_q == CW'(STROBE_CYCLES + 1)) ? run_q : run_q + 1'b1;
        else             run_q <= '0;
    end

    AST_STROBE_MAX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(STROBE_CYCLES)); // R3

    AST_VALID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (slot_addr != '0)); // R6

    AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |-> (slot_addr == '0)); // R7

    AST_VALID_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_valid) |-> $past(strobe)); // R6

    AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_cmd || $past(latch_cmd)) |=> ($stable(slot_addr) && $stable(slot_valid))); // R8
endmodule

bind split_addr_encoder split_addr_encoder_chk #(
    .ADDR_W(ADDR_W), .STROBE_CYCLES(STROBE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .latch_cmd(latch_cmd), .strobe(strobe),
    .slot_addr(slot_addr), .slot_valid(slot_valid)
);

// File: tb/tb_split_addr_encoder.sv
module tb_split_addr_encoder;
    localparam int NB = 15;
    localparam int SC = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] btn_raw = '0;
    logic          latch_cmd = 1'b0;
    logic          strobe;
    logic [3:0]    slot_addr;
    logic          slot_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    split_addr_encoder dut (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .latch_cmd(latch_cmd),
        .strobe(strobe), .slot_addr(slot_addr), .slot_valid(slot_valid)
    );

    // {buttons, expected slot}
    localparam logic [18:0] VEC [6] = '{
        {15'h0001, 4'd1},
        {15'h4000, 4'd15},
        {15'h0012, 4'd5},
        {15'h7FFF, 4'd15},
        {15'h0100, 4'd9},
        {15'h00C0, 4'd8}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // returns 1 if strobe seen high within n negedges
    task automatic wait_strobe(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n && !seen; i++) begin
            @(negedge clk);
            if (strobe) seen = 1'b1;
        end
    endtask

    task automatic press_and_check(input logic [NB-1:0] k, input logic [3:0] exp);
        bit seen;
        int w;
        btn_raw = k;
        wait_strobe(60, seen);
        check(seen, "R3 strobe appears", int'(seen), 1);
        if (seen) begin
            latch_cmd = 1'b1;
            w = 1;
            @(negedge clk);
            latch_cmd = 1'b0;
            check(slot_addr == exp, "R4 encoded slot", slot_addr, exp);
            check(slot_valid == 1'b1, "R6 valid after capture", slot_valid, 1);
            while (strobe && w < 100) begin
                w++;
                @(negedge clk);
            end
            check(w == SC, "R3 strobe width", w, SC);
        end
        btn_raw = '0;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        check(strobe == 1'b0 && slot_addr == 4'd0 && slot_valid == 1'b0,
              "R1 in reset", {strobe, slot_addr, slot_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(strobe == 1'b0 && slot_addr == 4'd0 && slot_valid == 1'b0,
              "R1 after reset", {strobe, slot_addr, slot_valid}, 0);

        for (int v = 0; v < 6; v++) press_and_check(VEC[v][18:4], VEC[v][3:0]);

        // R2: short glitch ignored
        btn_raw = 15'h0004;
        repeat (5) @(negedge clk);
        btn_raw = '0;
        wait_strobe(40, seen);
        check(!seen, "R2 short glitch", int'(seen), 0);

        // R5: held button, then an extra button, no re-strobe
        press_and_check_hold();

        // R7: latch edge outside strobe empties the register
        check(slot_valid == 1'b1, "R6 register still full", slot_valid, 1);
        latch_cmd = 1'b1;
        @(negedge clk);
        check(slot_addr == 4'd0 && slot_valid == 1'b0, "R7 empty on edge outside strobe",
              {slot_addr, slot_valid}, 0);

        // R8: held command across a strobe captures nothing
        btn_raw = 15'h0040;
        wait_strobe(60, seen);
        check(seen, "R8 strobe occurs", int'(seen), 1);
        repeat (SC + 2) @(negedge clk);
        check(slot_addr == 4'd0 && slot_valid == 1'b0, "R8 level does not capture",
              {slot_addr, slot_valid}, 0);
        latch_cmd = 1'b0;
        btn_raw = '0;
        repeat (30) @(negedge clk);

        done = 1'b1;
        finish_run();
    end

    task automatic press_and_check_hold();
        bit seen;
        btn_raw = 15'h0002;
        wait_strobe(60, seen);
        check(seen, "R5 first strobe", int'(seen), 1);
        latch_cmd = 1'b1;
        @(negedge clk);
        latch_cmd = 1'b0;
        check(slot_addr == 4'd2, "R4 single button", slot_addr, 2);
        repeat (SC + 2) @(negedge clk);
        wait_strobe(40, seen);
        check(!seen, "R5 no re-strobe while held", int'(seen), 0);
        btn_raw = 15'h0202;
        wait_strobe(40, seen);
        check(!seen, "R5 no strobe for added button", int'(seen), 0);
        btn_raw = '0;
        repeat (30) @(negedge clk);
        btn_raw = 15'h0004;
        wait_strobe(60, seen);
        check(seen, "R5 re-armed after release", int'(seen), 1);
        latch_cmd = 1'b1;
        @(negedge clk);
        latch_cmd = 1'b0;
        check(slot_addr == 4'd3, "R5 new slot after re-arm", slot_addr, 3);
        btn_raw = '0;
        repeat (30) @(negedge clk);
    endtask
endmodule